// File: doc/BRIEF.md
# Bus-Side Register Block with Read Side Effects

This block is a single-master AHB-Lite subordinate holding a small set of registers. It has ordinary read/write control words, a sticky event register that clears when read, and a receive queue whose data word pops one entry on every read. Local hardware raises event bits through a set vector and loads the queue through a push port with a ready signal.

The block captures the address phase and carries out the access one cycle later, in the data phase. Reads, writes and side effects all depend on a qualifying condition: the slot is selected, `hready` is high, and the transfer type is a real one. A parked or stale address seen during IDLE or BUSY slots, during unselected slots, or during stalled slots cannot pop the queue, clear events or change a control word. The block always completes with no wait state and an OKAY response.

Top module: `ahb_sidefx_regs`

## Requirements
- R1: During an address phase with `htrans` 2'b00 (IDLE) or 2'b01 (BUSY), no register is written, no event bit is cleared and the queue is not popped, whatever `haddr`, `hwrite` and `hwdata` carry.
- R2: An access qualifies only when `hsel` and `hready` are both high and `htrans` is 2'b10 (NONSEQ) or 2'b11 (SEQ). With `hsel` low or `hready` low, the slot has no effect.
- R3: `hreadyout` is high and `hresp` is 0 (OKAY) in every cycle. This includes IDLE slots and accesses to unused offsets.
- R4: A qualified write takes `hwdata` from the cycle after its address phase. A qualified read drives `hrdata` in that same cycle. `hrdata` is zero in any cycle that is not the data phase of a qualified read.
- R5: Control words sit at word index 0 to NUM_CTRL-1, where the word index is `haddr[ADDR_W-1:2]`. They read back the last value written to them.
- R6: The event word sits at word index NUM_CTRL, in bits STAT_W-1:0. A high bit of `stat_set` makes its event bit stay high. A qualified read returns the event bits and then clears them. Writes to the event word are ignored.
- R7: If a `stat_set` bit is high in the same cycle as the data phase of a clearing read, that bit is high after the clear.
- R8: The queue data word sits at word index NUM_CTRL+1. A qualified read returns the oldest entry and removes it. Writes to it are ignored.
- R9: A qualified read of the queue data word while the queue is empty returns zero and does not change the queue contents or their order.
- R10: `push_ready` is high while the queue holds fewer than FIFO_DEPTH entries. `push_data` is stored when `push_valid` and `push_ready` are both high at a clock edge, and is dropped otherwise. Entries leave the queue in the order they arrived.
- R11: Any word index above NUM_CTRL+1 reads as zero, ignores writes and gets OKAY.
- R12: While `hresetn` is low and after it rises, the control words are zero, the event bits are zero, the queue is empty, `push_ready` is high, `hreadyout` is high and `hresp` is OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slot select for this block |
| haddr | input | ADDR_W | Byte address; the word index is bits ADDR_W-1:2 |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | High for a write in the address phase |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; the previous slot completes |
| hreadyout | output | 1 | This block's ready, always high |
| hresp | output | 1 | Response, always OKAY (0) |
| hrdata | output | DATA_W | Read data in the data phase of a qualified read |
| stat_set | input | STAT_W | Hardware event pulses that set event bits |
| push_valid | input | 1 | Local request to store `push_data` in the queue |
| push_data | input | DATA_W | Entry to store |
| push_ready | output | 1 | Queue has space |

## Verification
The hardest case to reach from the ports is the one where an unqualified slot carries the exact address of a side-effect word while something is waiting to be lost. For example, an IDLE or BUSY slot points at the queue data word while the queue holds entries, or at the event word while event bits are set. The stimulus fills the queue and raises events first. It then parks the address on those words under every unqualified combination (IDLE, BUSY, `hsel` low, `hready` low, with write high and with write low) before a real read drains them. A clearing read that lands in the same cycle as a new event, and a read of an empty queue that coincides with a push, are placed on purpose. A long random phase then mixes all of these with ordinary traffic, checked against a behavioural model every cycle.

// File: rtl/sidefx_pkg.sv
package sidefx_pkg;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } htrans_e;

   localparam logic RESP_OKAY = 1'b0;

   // A transfer type carries a real access when its upper bit is set.
   function automatic logic is_real_xfer(input logic [1:0] t);
      return t[1];
   endfunction

endpackage

// File: rtl/sidefx_aphase.sv
module sidefx_aphase #(
   parameter int IDX_W = 6
) (
   input  logic             hclk,
   input  logic             hresetn,
   input  logic             hsel,
   input  logic             hready,
   input  logic [1:0]       htrans,
   input  logic             hwrite,
   input  logic [IDX_W-1:0] idx_in,
   output logic             acc_q,
   output logic             wr_q,
   output logic [IDX_W-1:0] idx_q
);
   import sidefx_pkg::*;

   logic qualify;

   assign qualify = hsel && hready && is_real_xfer(htrans);

   // Address and direction are only latched for a qualified slot,
   // so no stale address ever reaches a register.
   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         acc_q <= 1'b0;
         wr_q  <= 1'b0;
         idx_q <= '0;
      end else begin
         acc_q <= qualify;
         if (qualify) begin
            wr_q  <= hwrite;
            idx_q <= idx_in;
         end
      end
   end

endmodule

// File: rtl/sidefx_status.sv
module sidefx_status #(
   parameter int STAT_W = 8
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic [STAT_W-1:0] set_i,
   input  logic              clr_i,
   output logic [STAT_W-1:0] stat_q
);
   logic [STAT_W-1:0] kept;

   assign kept = clr_i ? '0 : stat_q;

   // A set arriving with the clear survives it.
   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) stat_q <= '0;
      else          stat_q <= kept | set_i;
   end

endmodule

// File: rtl/sidefx_fifo.sv
module sidefx_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic                     hclk,
   input  logic                     hresetn,
   input  logic                     push_i,
   input  logic [DATA_W-1:0]        din,
   input  logic                     pop_i,
   output logic [DATA_W-1:0]        dout,
   output logic                     full,
   output logic                     empty,
   output logic [$clog2(DEPTH):0]   count
);
   localparam int PW = $clog2(DEPTH);
   localparam logic [PW:0] DEPTH_C = (PW+1)'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wp, rp;
   logic              do_push, do_pop;

   assign full    = (count == DEPTH_C);
   assign empty   = (count == '0);
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && !empty;
   assign dout    = empty ? '0 : mem[rp];

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge hclk) begin
      if (do_push) mem[wp] <= din;
   end

endmodule

// File: rtl/ahb_sidefx_regs.sv
module ahb_sidefx_regs #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int NUM_CTRL   = 2,
   parameter int STAT_W     = 8,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [DATA_W-1:0] hwdata,
   input  logic              hready,
   output logic              hreadyout,
   output logic              hresp,
   output logic [DATA_W-1:0] hrdata,
   input  logic [STAT_W-1:0] stat_set,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   output logic              push_ready
);
   import sidefx_pkg::*;

   localparam int IDX_W = ADDR_W - 2;
   localparam int PW    = $clog2(FIFO_DEPTH);
   localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(NUM_CTRL);
   localparam logic [IDX_W-1:0] FIFO_IDX = IDX_W'(NUM_CTRL + 1);

   initial begin
      assert (ADDR_W >= 3 && (NUM_CTRL + 2) <= (1 << IDX_W))
         else $error("address space too small for the register set");
      assert (FIFO_DEPTH >= 2 && (1 << PW) == FIFO_DEPTH)
         else $error("queue depth must be a power of two, at least 2");
      assert (STAT_W >= 1 && STAT_W <= DATA_W)
         else $error("event width must fit the data bus");
      assert (NUM_CTRL >= 1)
         else $error("at least one control word is needed");
   end

   logic              acc_q, wr_q;
   logic [IDX_W-1:0]  idx_q;
   logic              rd_go, wr_go, clr_go, pop_go;
   logic [STAT_W-1:0] stat_q;
   logic [DATA_W-1:0] fifo_dout;
   logic              fifo_full, fifo_empty;
   logic [PW:0]       fifo_cnt;
   logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_bus;

   sidefx_aphase #(.IDX_W(IDX_W)) u_aphase (
      .hclk    (hclk),
      .hresetn (hresetn),
      .hsel    (hsel),
      .hready  (hready),
      .htrans  (htrans),
      .hwrite  (hwrite),
      .idx_in  (haddr[ADDR_W-1:2]),
      .acc_q   (acc_q),
      .wr_q    (wr_q),
      .idx_q   (idx_q)
   );

   assign rd_go  = acc_q && !wr_q;
   assign wr_go  = acc_q && wr_q;
   assign clr_go = rd_go && (idx_q == STAT_IDX);
   assign pop_go = rd_go && (idx_q == FIFO_IDX);

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
      logic [DATA_W-1:0] word_q;
      logic              we;
      assign we = wr_go && (idx_q == IDX_W'(g));
      always_ff @(posedge hclk or negedge hresetn) begin
         if (!hresetn)  word_q <= '0;
         else if (we)   word_q <= hwdata;
      end
      assign ctrl_bus[g] = word_q;
   end

   sidefx_status #(.STAT_W(STAT_W)) u_status (
      .hclk    (hclk),
      .hresetn (hresetn),
      .set_i   (stat_set),
      .clr_i   (clr_go),
      .stat_q  (stat_q)
   );

   sidefx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .hclk    (hclk),
      .hresetn (hresetn),
      .push_i  (push_valid),
      .din     (push_data),
      .pop_i   (pop_go),
      .dout    (fifo_dout),
      .full    (fifo_full),
      .empty   (fifo_empty),
      .count   (fifo_cnt)
   );

   assign push_ready = !fifo_full;

   always_comb begin
      hrdata = '0;
      if (rd_go) begin
         if (idx_q == STAT_IDX)      hrdata = DATA_W'(stat_q);
         else if (idx_q == FIFO_IDX) hrdata = fifo_dout;
         else begin
            for (int i = 0; i < NUM_CTRL; i++)
               if (idx_q == IDX_W'(i)) hrdata = ctrl_bus[i];
         end
      end
   end

   assign hreadyout = 1'b1;
   assign hresp     = RESP_OKAY;

endmodule

// File: rtl/sidefx_chk.sv
module sidefx_chk #(
   parameter int STAT_W = 8,
   parameter int CNT_W  = 3,
   parameter int DEPTH  = 4
) (
   input logic              hclk,
   input logic              hresetn,
   input logic              hsel,
   input logic              hready,
   input logic [1:0]        htrans,
   input logic              hreadyout,
   input logic              hresp,
   input logic              acc_q,
   input logic              wr_go,
   input logic              clr_go,
   input logic              pop_go,
   input logic [STAT_W-1:0] stat_set,
   input logic [STAT_W-1:0] stat_q,
   input logic              push_valid,
   input logic [CNT_W-1:0]  fifo_cnt
);

   // R1
   idle_quiet_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (hsel && hready && !htrans[1]) |=> !(wr_go || clr_go || pop_go));

   // R2
   qual_capture_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (hsel && hready && htrans[1]) |=> acc_q);

   // R2
   unsel_quiet_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (!hsel || !hready) |=> !acc_q);

   // R3
   okay_resp_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (htrans == 2'b00) |=> (hreadyout && !hresp));

   // R7
   set_wins_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      clr_go |=> (stat_q == $past(stat_set)));

   // R9
   empty_pop_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (pop_go && fifo_cnt == '0 && !push_valid) |=> (fifo_cnt == '0));

   // R10
   fifo_bound_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      fifo_cnt <= CNT_W'(DEPTH));

endmodule

bind ahb_sidefx_regs sidefx_chk #(
   .STAT_W (STAT_W),
   .CNT_W  (PW + 1),
   .DEPTH  (FIFO_DEPTH)
) u_chk (
   .hclk       (hclk),
   .hresetn    (hresetn),
   .hsel       (hsel),
   .hready     (hready),
   .htrans     (htrans),
   .hreadyout  (hreadyout),
   .hresp      (hresp),
   .acc_q      (acc_q),
   .wr_go      (wr_go),
   .clr_go     (clr_go),
   .pop_go     (pop_go),
   .stat_set   (stat_set),
   .stat_q     (stat_q),
   .push_valid (push_valid),
   .fifo_cnt   (fifo_cnt)
);

// File: tb/ahb_sidefx_regs_test.sv
module ahb_sidefx_regs_test;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NC = 2;
   localparam int SW = 8;
   localparam int FD = 4;
   localparam int SIDX = NC;
   localparam int QIDX = NC + 1;

   logic          hclk = 1'b0;
   logic          hresetn;
   logic          hsel;
   logic [AW-1:0] haddr;
   logic [1:0]    htrans;
   logic          hwrite;
   logic [DW-1:0] hwdata;
   logic          hready;
   logic          hreadyout;
   logic          hresp;
   logic [DW-1:0] hrdata;
   logic [SW-1:0] stat_set;
   logic          push_valid;
   logic [DW-1:0] push_data;
   logic          push_ready;

   ahb_sidefx_regs #(.DATA_W(DW), .ADDR_W(AW), .NUM_CTRL(NC),
                     .STAT_W(SW), .FIFO_DEPTH(FD)) uut (.*);

   always #10 hclk = ~hclk;

   int    total = 0;
   int    bad   = 0;
   string cur_req = "R12";

   logic [DW-1:0] m_ctrl [NC];
   logic [SW-1:0] m_stat;
   logic [DW-1:0] m_q [$];
   logic          p_acc;
   logic          p_wr;
   int            p_idx;
   logic [DW-1:0] nxt_wdata;

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Apply the inputs held through the last rising edge to the model.
   task automatic model_edge();
      logic clr;
      logic full_before;
      clr = 1'b0;
      full_before = (m_q.size() >= FD);
      if (p_acc) begin
         if (p_wr) begin
            if (p_idx < NC) m_ctrl[p_idx] = hwdata;
         end else if (p_idx == SIDX) begin
            clr = 1'b1;
         end else if (p_idx == QIDX && m_q.size() > 0) begin
            void'(m_q.pop_front());
         end
      end
      m_stat = (clr ? '0 : m_stat) | stat_set;
      if (push_valid && !full_before) m_q.push_back(push_data);
      p_acc = hsel && hready && htrans[1];
      if (p_acc) begin
         p_wr  = hwrite;
         p_idx = int'(haddr[AW-1:2]);
      end
   endtask

   function automatic logic [DW-1:0] model_rdata();
      if (!p_acc || p_wr)  return '0;
      if (p_idx < NC)      return m_ctrl[p_idx];
      if (p_idx == SIDX)   return DW'(m_stat);
      if (p_idx == QIDX)   return (m_q.size() > 0) ? m_q[0] : '0;
      return '0;
   endfunction

   // One clock: wait for the falling edge, update the model, compare.
   task automatic step();
      @(negedge hclk);
      model_edge();
      chk(cur_req, "hrdata", hrdata, model_rdata());
      chk("R3", "hreadyout", DW'(hreadyout), DW'(1'b1));
      chk("R3", "hresp", DW'(hresp), '0);
      chk("R10", "push_ready", DW'(push_ready), DW'(m_q.size() < FD));
   endtask

   task automatic xfer(input logic sel, input logic [1:0] tr, input logic wr,
                       input int idx, input logic [DW-1:0] wd);
      hsel   = sel;
      htrans = tr;
      hwrite = wr;
      haddr  = {idx[AW-3:0], 2'b01};
      hwdata = nxt_wdata;
      nxt_wdata = wd;
      step();
   endtask

   task automatic push(input logic [DW-1:0] d);
      push_valid = 1'b1;
      push_data  = d;
      xfer(1'b0, 2'b00, 1'b0, 0, '0);
      push_valid = 1'b0;
      push_data  = '0;
   endtask

   initial begin
      repeat (100000) @(posedge hclk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      hresetn = 1'b0; hsel = 0; haddr = '0; htrans = 2'b00; hwrite = 0;
      hwdata = '0; hready = 1'b1; stat_set = '0; push_valid = 0;
      push_data = '0; nxt_wdata = '0;
      for (int i = 0; i < NC; i++) m_ctrl[i] = '0;
      m_stat = '0; p_acc = 0; p_wr = 0; p_idx = 0;

      // R12: reset values
      repeat (3) @(negedge hclk);
      chk("R12", "hreadyout", DW'(hreadyout), DW'(1'b1));
      chk("R12", "hresp", DW'(hresp), '0);
      chk("R12", "push_ready", DW'(push_ready), DW'(1'b1));
      chk("R12", "hrdata", hrdata, '0);
      hresetn = 1'b1;
      cur_req = "R12";
      for (int i = 0; i < QIDX + 1; i++) xfer(1, 2'b10, 0, i, '0);
      xfer(0, 2'b00, 0, 0, '0);

      // R5 / R4: write then read back to back
      cur_req = "R5";
      xfer(1, 2'b10, 1, 0, 32'hA5A5_0001);
      xfer(1, 2'b10, 1, 1, 32'h5A5A_0002);
      cur_req = "R4";
      xfer(1, 2'b10, 0, 0, '0);
      xfer(1, 2'b11, 0, 1, '0);
      xfer(1, 2'b10, 1, 1, 32'h1234_5678);
      xfer(1, 2'b10, 0, 1, '0);
      xfer(0, 2'b00, 0, 0, '0);

      // R1 / R2: fill queue and events, then park on them unqualified
      cur_req = "R1";
      push(32'h1111_0001);
      push(32'h2222_0002);
      stat_set = 8'h81; xfer(0, 2'b00, 0, 0, '0); stat_set = '0;
      for (int w = 0; w < 2; w++) begin
         xfer(1, 2'b00, w[0], QIDX, 32'hDEAD_0000);
         xfer(1, 2'b01, w[0], QIDX, 32'hDEAD_0001);
         xfer(1, 2'b00, w[0], SIDX, 32'hDEAD_0002);
         xfer(1, 2'b01, w[0], SIDX, 32'hDEAD_0003);
         xfer(1, 2'b00, 1'b1, 0, 32'hDEAD_0004);
      end
      cur_req = "R2";
      xfer(0, 2'b10, 0, QIDX, '0);
      xfer(0, 2'b11, 1, 0, 32'hBAD0_0000);
      hready = 1'b0;
      xfer(1, 2'b10, 0, QIDX, '0);
      xfer(1, 2'b10, 0, SIDX, '0);
      xfer(1, 2'b10, 1, 1, 32'hBAD0_0001);
      hready = 1'b1;
      xfer(1, 2'b10, 0, 0, '0);
      xfer(1, 2'b10, 0, 1, '0);

      // R6: clearing read of events
      cur_req = "R6";
      xfer(1, 2'b10, 0, SIDX, '0);
      xfer(1, 2'b10, 0, SIDX, '0);
      xfer(1, 2'b10, 1, SIDX, 32'hFFFF_FFFF);
      xfer(1, 2'b10, 0, SIDX, '0);

      // R7: event in the cycle of the clearing data phase
      cur_req = "R7";
      stat_set = 8'h0F; xfer(1, 2'b10, 0, SIDX, '0);
      stat_set = 8'h30; xfer(0, 2'b00, 0, 0, '0);
      stat_set = '0;
      xfer(1, 2'b10, 0, SIDX, '0);
      xfer(0, 2'b00, 0, 0, '0);

      // R8: pops in order, writes ignored
      cur_req = "R8";
      xfer(1, 2'b10, 1, QIDX, 32'hCAFE_0000);
      xfer(1, 2'b10, 0, QIDX, '0);
      xfer(1, 2'b11, 0, QIDX, '0);
      xfer(0, 2'b00, 0, 0, '0);

      // R9: empty reads, including one coinciding with a push
      cur_req = "R9";
      xfer(1, 2'b10, 0, QIDX, '0);
      push_valid = 1'b1; push_data = 32'h3333_0003;
      xfer(1, 2'b10, 0, QIDX, '0);
      push_valid = 1'b0;
      xfer(0, 2'b00, 0, 0, '0);
      xfer(1, 2'b10, 0, QIDX, '0);
      xfer(1, 2'b10, 0, QIDX, '0);
      xfer(0, 2'b00, 0, 0, '0);

      // R10: fill past full
      cur_req = "R10";
      for (int i = 0; i < FD + 2; i++) push(32'h4000_0000 + DW'(i));
      for (int i = 0; i < FD + 1; i++) xfer(1, 2'b10, 0, QIDX, '0);
      xfer(0, 2'b00, 0, 0, '0);

      // R11: unused offsets
      cur_req = "R11";
      xfer(1, 2'b10, 1, QIDX + 1, 32'h7777_7777);
      xfer(1, 2'b10, 1, 63, 32'h8888_8888);
      xfer(1, 2'b10, 0, QIDX + 1, '0);
      xfer(1, 2'b10, 0, 63, '0);
      xfer(1, 2'b10, 0, 0, '0);
      xfer(0, 2'b00, 0, 0, '0);

      // Mixed traffic across all rules
      cur_req = "R1";
      for (int i = 0; i < 600; i++) begin
         hready     = ($urandom % 8) != 0;
         stat_set   = (($urandom % 4) == 0) ? SW'($urandom) : '0;
         push_valid = ($urandom % 3) == 0;
         push_data  = $urandom;
         xfer(($urandom % 4) != 0, 2'($urandom), 1'($urandom),
              int'($urandom % 6), $urandom);
      end
      hready = 1'b1; stat_set = '0; push_valid = 1'b0;
      xfer(0, 2'b00, 0, 0, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule